// File: doc/BRIEF.md
# Read latency and byte-mask pipeline

This block is the data-path timing stage of a synchronous DRAM model. Read words from the array side enter with a valid flag. They leave on a 16-bit output bus after a programmable number of clocks: one, two or three. Each of the two byte lanes has its own output enable, and a per-lane mask input can blank either lane. A read mask acts two clocks after it is sampled. A write mask acts in the same clock, through a per-lane write strobe that goes to the array.

A stop pulse models a precharge or burst-stop command arriving during a read. Words already in flight still drain. Nothing sampled from the stop edge onward is driven until a new read begins. Because of this, the bus goes quiet exactly latency cycles after the stop. A write beat that coincides with the stop is not written. The latency comes from a register that loads only on a mode-register write strobe.

Top module: `rdlat_mask_pipe`

## Requirements
- R1: After reset, `dq_oe_o` is 0 and the latency is 3.
- R2: When `lat_load_i` is high on a clock edge and `cas_lat_i` is 1, 2 or 3, that value becomes the latency for words sampled on later edges.
- R3: A load with `cas_lat_i` = 0 is ignored, and the latency keeps its previous value.
- R4: With latency n, a word sampled with `rd_valid_i` high on edge k is on `dq_o`, with both enable bits set unless masked, from just after edge k+n-1 until edge k+n.
- R5: `dq_oe_o` is 0 in every cycle that has no word scheduled for it.
- R6: A high `dqm_i[b]` on edge j clears `dq_oe_o[b]` for the cycle after edge j+1. Bit 0 covers `dq_o[7:0]` and bit 1 covers `dq_o[15:8]`, each independently.
- R7: `wr_strb_o[b]` is high in the same cycle, with no register, when `wr_en_i` is high, `stop_i` is low and `dqm_i[b]` is low.
- R8: A `stop_i` pulse on edge p stops every word sampled on edge p or later from being driven. Words sampled before p still appear. With latency n, the bus is idle from just after edge p+n-1 onward.
- R9: `wr_strb_o` is 0 in any cycle where `stop_i` is high.
- R10: After a stop, a word with `rd_start_i` high reopens the path. If `rd_start_i` and `stop_i` are high on the same edge, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat_i | input | 2 | Latency code, loaded on `lat_load_i` |
| lat_load_i | input | 1 | Mode-register write strobe |
| rd_start_i | input | 1 | First word of a new read |
| rd_valid_i | input | 1 | Read word valid |
| rd_data_i | input | 16 | Read word from the array |
| stop_i | input | 1 | Precharge or burst-stop interrupt |
| dqm_i | input | 2 | Byte masks: bit 0 low lane, bit 1 high lane |
| wr_en_i | input | 1 | Write beat present this cycle |
| dq_o | output | 16 | Read data bus |
| dq_oe_o | output | 2 | Per-lane output enable |
| wr_strb_o | output | 2 | Per-lane write strobe |

## Verification
Each result has its own timing. A read word sampled on edge k is due in the cycle after edge k+n-1. A read mask sampled on edge j is due in the cycle after edge j+1. A write strobe is due before the edge on which its inputs are sampled. A stop shows up n cycles after the edge that sampled it. The bench drives inputs at the falling edge and samples 1 ns later. It keeps per-cycle schedules indexed by the edge after which each value is visible, so each comparison reads from the slot of the preceding rising edge.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

  typedef enum logic {
    RD_OPEN = 1'b0,
    RD_CUT  = 1'b1
  } rd_gate_e;

  function automatic bit lat_legal(input int unsigned code, input int unsigned max_lat);
    return (code >= 1) && (code <= max_lat);
  endfunction

endpackage

// File: rtl/rdlat_mode_reg.sv
module rdlat_mode_reg #(
  parameter int MAX_LAT   = 3,
  parameter int RESET_LAT = 3,
  localparam int LAT_W    = $clog2(MAX_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] cas_i,
  output logic [LAT_W-1:0] lat_o
);

  logic [LAT_W-1:0] lat_q;

  // reserved codes leave the latency unchanged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= LAT_W'(RESET_LAT);
    end else if (load_i && rdlat_pkg::lat_legal(32'(cas_i), MAX_LAT)) begin
      lat_q <= cas_i;
    end
  end

  assign lat_o = lat_q;

endmodule

// File: rtl/rdlat_rd_gate.sv
module rdlat_rd_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic vld_i,
  input  logic stop_i,
  output logic pass_o
);

  import rdlat_pkg::*;

  rd_gate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (stop_i)       state_d = RD_CUT;
    else if (start_i) state_d = RD_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RD_OPEN;
    else         state_q <= state_d;
  end

  // stop wins over start on the same edge
  assign pass_o = vld_i & ~stop_i & (start_i | (state_q == RD_OPEN));

endmodule

// File: rtl/rdlat_delay_line.sv
module rdlat_delay_line #(
  parameter int DATA_W  = 16,
  parameter int MAX_LAT = 3,
  localparam int LAT_W  = $clog2(MAX_LAT + 1),
  localparam int DEPTH  = MAX_LAT - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sel_vld_o,
  output logic [DATA_W-1:0] sel_data_o
);

  logic [DEPTH-1:0]             st_v;
  logic [DEPTH-1:0][DATA_W-1:0] st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_v <= '0;
      st_d <= '0;
    end else begin
      st_v[0] <= vld_i;
      st_d[0] <= data_i;
      for (int i = 1; i < DEPTH; i++) begin
        st_v[i] <= st_v[i-1];
        st_d[i] <= st_d[i-1];
      end
    end
  end

  // latency 1 bypasses the line; latency n taps stage n-2
  always_comb begin
    sel_vld_o  = vld_i;
    sel_data_o = data_i;
    for (int i = 0; i < DEPTH; i++) begin
      if (lat_i == LAT_W'(i + 2)) begin
        sel_vld_o  = st_v[i];
        sel_data_o = st_d[i];
      end
    end
  end

endmodule

// File: rtl/rdlat_wr_strobe.sv
module rdlat_wr_strobe #(
  parameter int LANES = 2
) (
  input  logic             wr_en_i,
  input  logic             stop_i,
  input  logic [LANES-1:0] dqm_i,
  output logic [LANES-1:0] strb_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign strb_o[l] = wr_en_i & ~stop_i & ~dqm_i[l];
  end

endmodule

// File: rtl/rdlat_mask_pipe.sv
module rdlat_mask_pipe #(
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter int MAX_LAT   = 3,
  parameter int RESET_LAT = 3,
  localparam int LANES    = DATA_W / LANE_W,
  localparam int LAT_W    = $clog2(MAX_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LAT_W-1:0]  cas_lat_i,
  input  logic              lat_load_i,
  input  logic              rd_start_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              stop_i,
  input  logic [LANES-1:0]  dqm_i,
  input  logic              wr_en_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe_o,
  output logic [LANES-1:0]  wr_strb_o
);

  logic [LAT_W-1:0]  lat_q;
  logic              rd_pass;
  logic              sel_vld;
  logic [DATA_W-1:0] sel_data;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] dq_q;
  logic [LANES-1:0]  oe_q;

  rdlat_mode_reg #(.MAX_LAT(MAX_LAT), .RESET_LAT(RESET_LAT)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lat_load_i),
    .cas_i  (cas_lat_i),
    .lat_o  (lat_q)
  );

  rdlat_rd_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rd_start_i),
    .vld_i   (rd_valid_i),
    .stop_i  (stop_i),
    .pass_o  (rd_pass)
  );

  rdlat_delay_line #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lat_i      (lat_q),
    .vld_i      (rd_pass),
    .data_i     (rd_data_i),
    .sel_vld_o  (sel_vld),
    .sel_data_o (sel_data)
  );

  rdlat_wr_strobe #(.LANES(LANES)) u_wstrb (
    .wr_en_i (wr_en_i),
    .stop_i  (stop_i),
    .dqm_i   (dqm_i),
    .strb_o  (wr_strb_o)
  );

  // mask_q adds the first of the two read-mask clocks, the output register the second
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      dq_q   <= '0;
      oe_q   <= '0;
    end else begin
      mask_q <= dqm_i;
      dq_q   <= sel_data;
      oe_q   <= {LANES{sel_vld}} & ~mask_q;
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;

endmodule

// File: rtl/rdlat_mask_pipe_chk.sv
module rdlat_mask_pipe_chk #(
  parameter int LANES = 2,
  parameter int LAT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LAT_W-1:0] lat_q,
  input logic [LAT_W-1:0] cas_lat_i,
  input logic             lat_load_i,
  input logic             rd_valid_i,
  input logic             stop_i,
  input logic [LANES-1:0] dqm_i,
  input logic             wr_en_i,
  input logic [LANES-1:0] dq_oe_o,
  input logic [LANES-1:0] wr_strb_o
);

  assert_lat_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_load_i && cas_lat_i != '0) |=> (lat_q == $past(cas_lat_i)));

  assert_rsvd_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_load_i && cas_lat_i == '0) |=> $stable(lat_q));

  assert_lat1_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && lat_q == 1 && $past(lat_q) == 1 && dq_oe_o != '0) |-> $past(rd_valid_i));

  assert_lat3_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && lat_q == 3 && $past(lat_q, 3) == 3 && dq_oe_o != '0)
      |-> $past(rd_valid_i, 3));

  assert_rd_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni, 2) |-> ((dq_oe_o & $past(dqm_i, 2)) == '0));

  assert_wr_same_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !stop_i) |-> (wr_strb_o == ~dqm_i));

  assert_stop_cut_lat2_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && lat_q == 2 && $past(lat_q, 2) == 2 && $past(stop_i, 2))
      |-> (dq_oe_o == '0));

  assert_stop_cut_lat1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && lat_q == 1 && $past(lat_q) == 1 && $past(stop_i)) |-> (dq_oe_o == '0));

  assert_stop_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> (wr_strb_o == '0));

endmodule

bind rdlat_mask_pipe rdlat_mask_pipe_chk #(.LANES(LANES), .LAT_W(LAT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lat_q      (lat_q),
  .cas_lat_i  (cas_lat_i),
  .lat_load_i (lat_load_i),
  .rd_valid_i (rd_valid_i),
  .stop_i     (stop_i),
  .dqm_i      (dqm_i),
  .wr_en_i    (wr_en_i),
  .dq_oe_o    (dq_oe_o),
  .wr_strb_o  (wr_strb_o)
);

// File: tb/rdlat_mask_pipe_test.sv
`timescale 1ns/1ps
module rdlat_mask_pipe_test;

  localparam int NV = 40;
  // {load, cas[1:0], start, valid, stop, dqm[1:0], wr_en, exp_wstrb[1:0]}
  localparam logic [10:0] VEC [NV] = '{
    11'b0_00_0_0_0_00_0_00, // 0 idle
    11'b0_00_1_1_0_00_0_00, // 1 read, latency 3
    11'b0_00_0_1_0_00_0_00,
    11'b0_00_0_1_0_01_0_00, // 3 mask low lane of word 2
    11'b0_00_0_1_0_10_0_00, // 4 mask high lane of word 3
    11'b0_00_0_0_0_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b1_01_0_0_0_00_0_00, // 7 latency 1
    11'b0_00_1_1_0_00_0_00,
    11'b0_00_0_1_0_00_0_00,
    11'b0_00_0_1_1_00_0_00, // 10 stop
    11'b0_00_0_1_0_00_0_00, // 11 blocked
    11'b0_00_1_1_0_00_0_00, // 12 reopen
    11'b0_00_0_0_0_01_1_10, // 13 write masks
    11'b0_00_0_0_0_10_1_01,
    11'b0_00_0_0_0_11_1_00,
    11'b0_00_0_0_1_00_1_00, // 16 write during stop
    11'b0_00_0_0_0_00_1_11,
    11'b1_00_0_0_0_00_0_00, // 18 reserved code
    11'b0_00_1_1_0_00_0_00,
    11'b1_10_0_0_0_00_0_00, // 20 latency 2
    11'b0_00_1_1_0_11_0_00,
    11'b0_00_0_1_0_00_0_00,
    11'b0_00_0_1_0_00_0_00,
    11'b0_00_0_1_1_00_0_00, // 24 stop
    11'b0_00_0_1_0_00_0_00,
    11'b0_00_1_1_1_00_0_00, // 26 stop with start
    11'b0_00_0_1_0_00_0_00,
    11'b0_00_1_1_0_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b1_11_0_0_0_00_0_00, // 32 latency 3
    11'b0_00_1_1_0_00_0_00,
    11'b0_00_0_1_1_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b0_00_0_0_0_00_0_00,
    11'b0_00_0_0_0_00_0_00
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cas_lat_i = '0;
  logic        lat_load_i = 1'b0, rd_start_i = 1'b0, rd_valid_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic        stop_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0]  dqm_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o, wr_strb_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdlat_mask_pipe uut (
    .clk_i(clk), .rst_ni(rst_ni), .cas_lat_i(cas_lat_i), .lat_load_i(lat_load_i),
    .rd_start_i(rd_start_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .stop_i(stop_i), .dqm_i(dqm_i), .wr_en_i(wr_en_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .wr_strb_o(wr_strb_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle();
    lat_load_i = 0; cas_lat_i = '0; rd_start_i = 0; rd_valid_i = 0;
    stop_i = 0; dqm_i = '0; wr_en_i = 0;
  endtask

  task automatic load_lat(input logic [1:0] code);
    @(negedge clk); idle(); lat_load_i = 1; cas_lat_i = code;
    @(negedge clk); idle();
  endtask

  // returns the number of falling edges until the word appears
  task automatic rd_probe(output int seen);
    seen = 0;
    @(negedge clk); idle(); rd_start_i = 1; rd_valid_i = 1; rd_data_i = 16'hBEEF;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); idle();
      #1;
      if (dq_oe_o != 2'b00 && seen == 0) seen = i;
    end
  endtask

  task automatic watch_quiet(input string tag, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); idle(); #1;
      chk(tag, 16'(dq_oe_o), 16'h0);
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic        ev [NV+4];
    logic [15:0] ed [NV+4];
    logic [1:0]  mk [NV+4];
    int lat_m, seen;
    bit blocked;
    for (int s = 0; s < NV + 4; s++) begin ev[s] = 0; ed[s] = '0; mk[s] = '0; end
    lat_m = 3; blocked = 0;

    idle();
    repeat (3) @(negedge clk);
    #1; chk("R1 oe in reset", 16'(dq_oe_o), 16'h0);
    @(negedge clk);
    rst_ni = 1;

    for (int c = 0; c < NV; c++) begin
      logic [10:0] v;
      logic [1:0] eoe;
      bit kept;
      v = VEC[c];
      lat_load_i = v[10]; cas_lat_i = v[9:8]; rd_start_i = v[7]; rd_valid_i = v[6];
      stop_i = v[5]; dqm_i = v[4:3]; wr_en_i = v[2];
      rd_data_i = 16'h3C00 ^ 16'(c * 273);
      #1;
      eoe = (c == 0) ? 2'b00 : (ev[c-1] ? ~mk[c-1] : 2'b00);
      chk((c == 0) ? "R1 oe" : (mk[c-1] != 0 && ev[c-1]) ? "R6 read mask" :
          ev[c-1] ? "R4 read enable" : "R5 idle enable", 16'(dq_oe_o), 16'(eoe));
      if (eoe[0]) chk("R4 low lane data", 16'(dq_o[7:0]), 16'(ed[c-1][7:0]));
      if (eoe[1]) chk("R4 high lane data", 16'(dq_o[15:8]), 16'(ed[c-1][15:8]));
      chk(v[5] ? "R9 stop write" : "R7 write strobe", 16'(wr_strb_o), 16'(v[1:0]));
      // schedule per requirements
      kept = v[6] && !v[5] && (v[7] || !blocked);
      if (kept) begin ev[c+lat_m-1] = 1; ed[c+lat_m-1] = rd_data_i; end
      mk[c+1] = v[4:3];
      if (v[5]) blocked = 1; else if (v[7]) blocked = 0;
      if (v[10] && v[9:8] != 0) lat_m = int'(v[9:8]);
      @(negedge clk);
    end
    idle();

    // R1: reset mid-read clears enables and restores latency 3
    rd_start_i = 1; rd_valid_i = 1;
    @(negedge clk); idle(); rst_ni = 0;
    #1; chk("R1 oe after async reset", 16'(dq_oe_o), 16'h0);
    @(negedge clk); rst_ni = 1;
    rd_probe(seen); chk("R1 reset latency", 16'(seen), 16'd3);

    // R2 / R3
    load_lat(2'd2); rd_probe(seen); chk("R2 latency 2", 16'(seen), 16'd2);
    load_lat(2'd0); rd_probe(seen); chk("R3 reserved code", 16'(seen), 16'd2);
    load_lat(2'd1); rd_probe(seen); chk("R2 latency 1", 16'(seen), 16'd1);
    load_lat(2'd2);

    // R8: word before stop drains, words after do not
    @(negedge clk); idle(); rd_start_i = 1; rd_valid_i = 1; rd_data_i = 16'h1234;
    @(negedge clk); idle(); stop_i = 1; rd_valid_i = 1; rd_data_i = 16'h5678;
    #1; chk("R8 before arrival", 16'(dq_oe_o), 16'h0);
    @(negedge clk); idle(); rd_valid_i = 1;
    #1; chk("R8 pre-stop word enable", 16'(dq_oe_o), 16'h3);
    chk("R8 pre-stop word data", dq_o, 16'h1234);
    watch_quiet("R8 cut after stop", 4);

    // R10: stop beats start on the same edge, then a plain start reopens
    @(negedge clk); idle(); rd_start_i = 1; rd_valid_i = 1; stop_i = 1;
    watch_quiet("R10 stop wins", 4);
    rd_probe(seen); chk("R10 reopen", 16'(seen), 16'd2);

    finish_run();
  end

endmodule